// File: doc/BRIEF.md
# Selectable-Tap Watchdog Timer

This block is a watchdog built on a free-running binary counter (20 bits by default). The counter advances on a count tick. That tick comes from an independent slow oscillator tick input, or from the system clock divided by six. A 3-bit rate field picks one of the eight most significant counter bits. The rising transition of that bit is the timeout, so each step of the rate field doubles the period.

Software keeps the watchdog quiet by writing the byte pair 0xA5 then 0x5A to the service port, which returns the counter to zero. A timeout sets a sticky overflow flag. A static mode input, normally taken from a configuration fuse, decides what a timeout does. When it is 1, the timeout gives a one-cycle reset pulse, the independent oscillator tick is forced as the count source and the run control is ignored. When it is 0, the timeout raises an interrupt request that holds while the flag is set.

Top module: `tap_watchdog`

## Requirements
- R1: With the counter starting from zero, a timeout occurs on the count tick that sets counter bit CNT_W-8+rate_i, that is, after 2^(CNT_W-8+rate_i) ticks. Rate 0 selects the lowest of the eight upper bits and rate 7 selects the top bit.
- R2: With hw_mode_i=0, clk_sel_i=1 counts one tick per six system clocks from a free-running divider, and clk_sel_i=0 counts osc_tick_i.
- R3: With hw_mode_i=1, osc_tick_i is the count source whatever clk_sel_i holds.
- R4: With hw_mode_i=1, a timeout drives wdt_rst_o high for exactly one clock and keeps wdt_irq_o low, and the counter restarts from zero, so the next timeout follows a full period later.
- R5: With hw_mode_i=0, a timeout raises wdt_irq_o, which stays high while ovf_o is set, and never pulses wdt_rst_o. The counter keeps counting, so the next rise of the same bit comes two periods later.
- R6: ovf_o is set by a timeout and stays set until flag_clr_i is high at a clock edge. A timeout in the same cycle as a clear leaves the flag set.
- R7: The counter is cleared by a write of 0xA5 (wr_en_i=1) followed by a write of 0x5A as the next write. Any other byte written between them cancels the pair, and the counter keeps its count.
- R8: When a completing 0x5A write lands on the edge that would be a timeout, the service wins: no timeout occurs and the counter is zero.
- R9: With hw_mode_i=0 and run_i=0 the counter holds and no timeout occurs. With hw_mode_i=1, run_i is ignored.
- R10: During reset ovf_o, wdt_rst_o and wdt_irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| osc_tick_i | input | 1 | one-clock tick from the independent oscillator, synchronous to clk_i |
| hw_mode_i | input | 1 | static mode: 1 = reset on timeout, forced oscillator, always running |
| run_i | input | 1 | run control, used only when hw_mode_i=0 |
| clk_sel_i | input | 1 | 1 = system clock divided by six, 0 = oscillator tick |
| rate_i | input | 3 | timeout tap select |
| wr_en_i | input | 1 | service register write strobe |
| wr_data_i | input | 8 | service register write byte |
| flag_clr_i | input | 1 | clears the overflow flag |
| ovf_o | output | 1 | sticky overflow flag |
| wdt_rst_o | output | 1 | one-cycle reset request |
| wdt_irq_o | output | 1 | interrupt request |

## Verification
Two clashes are built on purpose. The first places the closing 0x5A write on the same edge that would set the selected tap bit. The bench checks that no flag appears and that a full period follows from that edge. The second holds flag_clr_i high on the timeout edge itself, and the bench expects the flag to remain set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;
  typedef enum logic {SRC_OSC = 1'b0, SRC_DIV = 1'b1} tick_src_e;
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic force_osc_i,
  input  logic clk_sel_i,
  output logic tick_o
);
  import wdt_pkg::*;
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             div_tick;
  tick_src_e        src;

  assign div_tick = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (div_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  always_comb begin
    src = (force_osc_i || !clk_sel_i) ? SRC_OSC : SRC_DIV;
    tick_o = (src == SRC_OSC) ? osc_tick_i : div_tick;
  end

  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_tick |=> !div_tick); // R2
endmodule

// File: rtl/wdt_feed.sv
module wdt_feed (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       feed_o
);
  import wdt_pkg::*;
  logic armed_q;

  assign feed_o = wr_en_i && armed_q && (wr_data_i == KEY_FIRE);

  // any write other than the arm key drops the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= (wr_data_i == KEY_ARM);
  end

  AST_FEED_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_o |=> !armed_q); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 20,
  parameter int TAP_N = 8,
  localparam int SEL_W = $clog2(TAP_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             feed_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] rate_i,
  output logic             expire_o
);
  localparam int TAP_LO = CNT_W - TAP_N;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [TAP_N-1:0] tap_cur, tap_nxt;
  logic             step;

  assign cnt_nxt = cnt_q + 1'b1;
  assign step    = active_i && tick_i;

  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign tap_cur[g] = cnt_q[TAP_LO+g];
    assign tap_nxt[g] = cnt_nxt[TAP_LO+g];
  end

  // timeout = selected tap going 0->1 on this increment
  assign expire_o = step && !feed_i && !tap_cur[rate_i] && tap_nxt[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (feed_i)                cnt_q <= '0;
    else if (expire_o && restart_i) cnt_q <= '0;
    else if (step)                  cnt_q <= cnt_nxt;
  end

  AST_FEED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (cnt_q == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !feed_i) |=> $stable(cnt_q)); // R9
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && restart_i) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/tap_watchdog.sv
module tap_watchdog #(
  parameter int CNT_W = 20,
  parameter int DIV   = 6,
  localparam int TAP_N = 8,
  localparam int SEL_W = $clog2(TAP_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             hw_mode_i,
  input  logic             run_i,
  input  logic             clk_sel_i,
  input  logic [SEL_W-1:0] rate_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             flag_clr_i,
  output logic             ovf_o,
  output logic             wdt_rst_o,
  output logic             wdt_irq_o
);
  logic cnt_tick, feed, expire, active;

  assign active = hw_mode_i || run_i;

  wdt_tick_src #(.DIV(DIV)) u_tick (
    .clk_i, .rst_ni, .osc_tick_i,
    .force_osc_i(hw_mode_i), .clk_sel_i, .tick_o(cnt_tick)
  );

  wdt_feed u_feed (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .feed_o(feed)
  );

  wdt_counter #(.CNT_W(CNT_W), .TAP_N(TAP_N)) u_cnt (
    .clk_i, .rst_ni, .tick_i(cnt_tick), .active_i(active),
    .feed_i(feed), .restart_i(hw_mode_i), .rate_i, .expire_o(expire)
  );

  logic ovf_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire && hw_mode_i;
      if (expire)          ovf_q <= 1'b1;  // set beats clear
      else if (flag_clr_i) ovf_q <= 1'b0;
    end
  end

  assign ovf_o     = ovf_q;
  assign wdt_rst_o = rst_q;
  assign wdt_irq_o = ovf_q && !hw_mode_i;

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_RST_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> ovf_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flag_clr_i) |=> ovf_o); // R6
  AST_FORCED_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && !osc_tick_i) |-> !cnt_tick); // R3
  AST_FEED_BEATS_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed && !ovf_o && !flag_clr_i) |=> !ovf_o); // R8
endmodule

// File: tb/tap_watchdog_tb.sv
module tap_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int LO = CNT_W - 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick = 1'b1, hw_mode = 1'b0, run = 1'b1, clk_sel = 1'b0;
  logic [2:0] rate = 3'd0;
  logic wr_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ovf, wrst, wirq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_watchdog #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick), .hw_mode_i(hw_mode),
    .run_i(run), .clk_sel_i(clk_sel), .rate_i(rate), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .flag_clr_i(flag_clr), .ovf_o(ovf),
    .wdt_rst_o(wrst), .wdt_irq_o(wirq)
  );

  // bit 4 = hw_mode, bit 3 = clk_sel, bits 2:0 = rate
  localparam logic [4:0] VEC [0:7] = '{
    5'b0_0_000, 5'b0_0_011, 5'b0_1_000, 5'b0_1_010,
    5'b1_1_000, 5'b1_0_111, 5'b0_0_111, 5'b1_1_101
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic feed();
    wr_byte(8'hA5);
    flag_clr = 1'b1;
    wr_byte(8'h5A);
    flag_clr = 1'b0;
  endtask

  task automatic wait_ovf(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ovf) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, n2, t;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(!ovf && !wrst && !wirq, "R10", {ovf, wrst, wirq}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R1, R2, R3, R4, R5
    for (int v = 0; v < 8; v++) begin
      hw_mode = VEC[v][4]; clk_sel = VEC[v][3]; rate = VEC[v][2:0];
      feed();
      t = 1 << (LO + rate);
      wait_ovf(n, 7 * t + 20);
      if (!hw_mode && clk_sel)
        chk(n > 6*t - 6 && n <= 6*t, "R2", n, 6*t);
      else
        chk(n == t, hw_mode ? "R3" : "R1", n, t);
      chk(wrst == hw_mode, "R4", wrst, hw_mode);
      chk(wirq == !hw_mode, "R5", wirq, !hw_mode);
      @(negedge clk);
      chk(wrst == 1'b0, "R4", wrst, 0);
    end

    // R5 / R6 / R4: second timeout interval and flag clear
    for (int m = 0; m < 2; m++) begin
      hw_mode = m[0]; clk_sel = 1'b0; rate = 3'd0;
      feed();
      wait_ovf(n, 100);
      repeat (2) @(negedge clk);
      chk(ovf == 1'b1, "R6", ovf, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(ovf == 1'b0, "R6", ovf, 0);
      wait_ovf(n2, 100);
      n2 = n2 + 3;
      chk(n2 == (m ? 16 : 32), m ? "R4" : "R5", n2, m ? 16 : 32);
    end

    // R7: cancelled pair does not clear, good pair does
    hw_mode = 1'b0; rate = 3'd0;
    feed();
    repeat (3) @(negedge clk);
    wr_byte(8'hA5); wr_byte(8'h33); wr_byte(8'h5A);
    wait_ovf(n, 100);
    chk(n == 10, "R7", n, 10);
    feed();
    repeat (3) @(negedge clk);
    wr_byte(8'hA5); wr_byte(8'h5A);
    wait_ovf(n, 100);
    chk(n == 16, "R7", n, 16);

    // R8: service on the timeout edge
    feed();
    repeat (14) @(negedge clk);
    wr_byte(8'hA5); wr_byte(8'h5A);
    chk(ovf == 1'b0, "R8", ovf, 0);
    wait_ovf(n, 100);
    chk(n == 16, "R8", n, 16);

    // R6: clear on the timeout edge loses
    feed();
    repeat (15) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(ovf == 1'b1, "R6", ovf, 1);

    // R9: run control
    run = 1'b0;
    feed();
    repeat (100) @(negedge clk);
    chk(ovf == 1'b0, "R9", ovf, 0);
    run = 1'b1;
    wait_ovf(n, 100);
    chk(n == 16, "R9", n, 16);
    run = 1'b0; hw_mode = 1'b1;
    feed();
    wait_ovf(n, 100);
    chk(n == 16, "R9", n, 16);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule